// File: doc/BRIEF.md
# Synchronous Block-Transfer Bus Slave

This block is the memory end of a synchronous bus whose address and data share one set of lines. A single master raises a request and receives a grant. In the first granted clock it presents a read/write flag, a two-bit length code and a start address. The slave then stalls the bus with a wait indication while its modelled memory array produces the first group of four 32-bit words. After that it moves one 64-bit bus word per clock, in address order, for the whole block.

Data is grouped in fours. The first group costs a long, fixed access latency. Each later group costs a short latency that overlaps the transfer of the group before it, so a short wait appears between groups only when the group latency is longer than the group's beats. Both latencies are set at elaboration. The grant stays up until the last word has moved. Two idle clocks then pass before the bus can be granted again. Writes use the same schedule: the master supplies a bus word on each beat, and that word is stored in the internal array. A block that does not fit inside the array is refused.

Top module: `blk_bus_slave`

## Requirements
- R1: During and after reset, `gnt_o`, `wait_o` and `beat_o` are low and `ad_o` is zero. Every array word reads back as zero until it is written.
- R2: With the slave idle, `req_i` high at a clock edge makes `gnt_o` high in the next cycle. `gnt_o` then stays high through the last beat of the accepted block.
- R3: The command is taken in one clock: the granted cycle in which `cmd_valid_i` is high. `wait_o` is high in the cycle right after it.
- R4: `cmd_len_i` selects the block length: 0, 1, 2 and 3 mean 4, 8, 12 and 16 32-bit words, which is 2, 4, 6 and 8 bus beats. Exactly that many beats occur.
- R5: Taking the command cycle as cycle 0, the first beat falls in cycle FIRST_LAT+1. `wait_o` is high in cycles 1 to FIRST_LAT.
- R6: A group holds 2 beats, and those beats occur in consecutive cycles. Group g begins g*max(GROUP_LAT,2) cycles after group 0. `wait_o` is high in any granted cycle without a beat, and `wait_o` and `beat_o` are never high together.
- R7: On a read, beat k drives on `ad_o` the array word at address A+k, where A is `ad_i[4:0]` at the command and the addresses count 64-bit words. `ad_o` is zero in cycles without a read beat.
- R8: On a write, the value on `ad_i` in beat k is stored at array word A+k.
- R9: After the last beat, `gnt_o` is low for exactly GAP_CYC (2) cycles even if `req_i` is held high. It rises in the following cycle.
- R10: A command is ignored if its start address plus its beat count is greater than 32, or if any bit of `ad_i` above bit 4 is set. An ignored command gives no wait and no beats, drops `gnt_o` in the next cycle, and leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Master asks for the bus |
| gnt_o | output | 1 | Bus granted to the master; held to the last beat |
| cmd_valid_i | input | 1 | Command present on the bus this cycle |
| rw_i | input | 1 | Command direction, 1 = write, 0 = read |
| cmd_len_i | input | 2 | Block length code (R4) |
| ad_i | input | 64 | Multiplexed bus from the master: address at command, data on write beats |
| ad_o | output | 64 | Read data during read beats, zero otherwise |
| wait_o | output | 1 | Slave stalls the granted bus |
| beat_o | output | 1 | A bus word moves in this cycle |

## Verification
Every length code is used for both writes and reads, at start addresses stepped across the whole array. The data on each beat is distinct, so words sent out of order, skipped or repeated show up at once, and each written block is read back. Every granted cycle is compared with the arithmetic beat schedule, so a wrong first latency, group period or beat count shows as a shifted or missing beat. A block that ends exactly at the top of the array is set against blocks that overrun it by a few words, and the overrunning writes are followed by reads that prove the array was not touched. Each gap is checked with the request held high, which separates an early re-grant from a late one.

// File: rtl/blk_bus_pkg.sv
// Shared types for the block-transfer bus slave.
// Assumes: one master, and a single clock domain.
package blk_bus_pkg;
    localparam int LEN_W = 2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_GAP,
        S_GRANT,
        S_LAT,
        S_XFER
    } bus_state_t;
endpackage

// File: rtl/blk_cmd_check.sv
// Command range check: decides whether a block fits inside the word array.
// Assumes: the address counts 64-bit bus words, and any address bit above
// the array index makes the command out of range.
module blk_cmd_check #(
    parameter int BUS_W  = 64,
    parameter int ADDR_W = 5,
    parameter int BPG    = 2,
    parameter int LEN_W  = 2
) (
    input  logic [BUS_W-1:0] addr_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             cmd_valid_i,
    output logic             accept_o,
    output logic             reject_o
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int SPAN_W = ADDR_W + 2;

    logic [SPAN_W-1:0] span;
    logic              high_clear;
    logic              fits;

    // End address of the block, one past its last word.
    assign span = SPAN_W'(int'(addr_i[ADDR_W-1:0]) + (int'(len_i) + 1) * BPG);
    // The address bits above the array index must all be zero.
    assign high_clear = (addr_i[BUS_W-1:ADDR_W] == '0);
    // The block fits only if it ends at or below the array top.
    assign fits = high_clear && (span <= SPAN_W'(DEPTH));
    // Split a presented command into accepted and refused.
    assign accept_o = cmd_valid_i && fits;
    assign reject_o = cmd_valid_i && !fits;
endmodule

// File: rtl/blk_word_store.sv
// Word array of the memory model: one write port and one combinational read port.
// Assumes: the whole array is cleared by reset, which keeps it small.
module blk_word_store #(
    parameter int BUS_W  = 64,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BUS_W-1:0]  wdata_i,
    output logic [BUS_W-1:0]  rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [BUS_W-1:0] mem [DEPTH];

    // Clear every word on reset, then store one word per write beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we_i) begin
            mem[addr_i] <= wdata_i;
        end
    end

    // Read the addressed word directly.
    assign rdata_o = mem[addr_i];

    // R8
    we_addr_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |-> !$isunknown(addr_i));
endmodule

// File: rtl/blk_bus_seq.sv
// Bus sequencer: grant, command capture, first-access latency, overlapped
// group schedule, beat pointer, and the idle gap after each block.
// Assumes: FIRST_LAT >= 1 and GAP_CYC >= 1.
module blk_bus_seq
    import blk_bus_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int GRP_W     = 2,
    parameter int BPG       = 2,
    parameter int FIRST_LAT = 40,
    parameter int GROUP_LAT = 4,
    parameter int GAP_CYC   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              cmd_valid_i,
    input  logic              rw_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [GRP_W-1:0]  last_grp_i,
    input  logic              accept_i,
    input  logic              reject_i,
    output logic              gnt_o,
    output logic              wait_o,
    output logic              beat_o,
    output logic              last_beat_o,
    output logic [ADDR_W-1:0] ptr_o,
    output logic              rw_o
);
    localparam int PER   = (GROUP_LAT > BPG) ? GROUP_LAT : BPG;
    localparam int LAT_W = (FIRST_LAT > 1) ? $clog2(FIRST_LAT) : 1;
    localparam int T_W   = $clog2(PER + 1);
    localparam int GAP_W = $clog2(GAP_CYC + 1);

    bus_state_t        state;
    logic [LAT_W-1:0]  lat_cnt;
    logic [T_W-1:0]    tcnt;
    logic [GRP_W-1:0]  grp;
    logic [GRP_W-1:0]  last_grp_q;
    logic [GAP_W-1:0]  gap_cnt;
    logic [ADDR_W-1:0] ptr_q;
    logic              rw_q;
    logic              in_beat_slot;
    logic              grp_end;

    // Beat slots are the first BPG cycles of each group period.
    assign in_beat_slot = (tcnt < T_W'(BPG));
    assign grp_end      = (tcnt == T_W'(PER - 1));

    // Decode the bus-facing outputs from the state.
    assign gnt_o       = (state == S_GRANT) || (state == S_LAT) || (state == S_XFER);
    assign beat_o      = (state == S_XFER) && in_beat_slot;
    assign wait_o      = (state == S_LAT) || ((state == S_XFER) && !in_beat_slot);
    assign last_beat_o = beat_o && (grp == last_grp_q) && (tcnt == T_W'(BPG - 1));
    assign ptr_o       = ptr_q;
    assign rw_o        = rw_q;

    // Main state machine and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            lat_cnt    <= '0;
            tcnt       <= '0;
            grp        <= '0;
            last_grp_q <= '0;
            gap_cnt    <= '0;
            ptr_q      <= '0;
            rw_q       <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (req_i) state <= S_GRANT;
                end
                S_GAP: begin
                    if (gap_cnt == GAP_W'(GAP_CYC - 1)) begin
                        state <= req_i ? S_GRANT : S_IDLE;
                    end else begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
                S_GRANT: begin
                    if (accept_i) begin
                        state      <= S_LAT;
                        lat_cnt    <= LAT_W'(FIRST_LAT - 1);
                        ptr_q      <= addr_i;
                        rw_q       <= rw_i;
                        last_grp_q <= last_grp_i;
                    end else if (reject_i || (!cmd_valid_i && !req_i)) begin
                        state <= S_IDLE;
                    end
                end
                S_LAT: begin
                    if (lat_cnt == '0) begin
                        state <= S_XFER;
                        tcnt  <= '0;
                        grp   <= '0;
                    end else begin
                        lat_cnt <= lat_cnt - 1'b1;
                    end
                end
                S_XFER: begin
                    if (beat_o) ptr_q <= ptr_q + 1'b1;
                    if (last_beat_o) begin
                        state   <= S_GAP;
                        gap_cnt <= '0;
                    end else if (grp_end) begin
                        tcnt <= '0;
                        grp  <= grp + 1'b1;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R2
    gnt_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnt_o) |-> $past(req_i));
    // R6
    beat_wait_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(beat_o && wait_o));
    // R5
    wait_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(wait_o) && !$past(beat_o)) |-> $past(cmd_valid_i));
    // R9
    gap_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(last_beat_o) |-> !gnt_o);
    // R9
    gap_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(last_beat_o, 2) |-> !gnt_o);
    // R10
    reject_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reject_i && gnt_o && !wait_o && !beat_o) |-> (!gnt_o && !wait_o));
endmodule

// File: rtl/blk_bus_slave.sv
// Top of the block-transfer bus slave: range check, sequencer and word array,
// plus the read data drive on the shared bus.
// Assumes: one master, which drives ad_i with the address at the command and
// with write data on write beats.
module blk_bus_slave
    import blk_bus_pkg::*;
#(
    parameter int BUS_W     = 64,
    parameter int WORD_W    = 32,
    parameter int GRP_WORDS = 4,
    parameter int ADDR_W    = 5,
    parameter int FIRST_LAT = 40,
    parameter int GROUP_LAT = 4,
    parameter int GAP_CYC   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    output logic             gnt_o,
    input  logic             cmd_valid_i,
    input  logic             rw_i,
    input  logic [1:0]       cmd_len_i,
    input  logic [BUS_W-1:0] ad_i,
    output logic [BUS_W-1:0] ad_o,
    output logic             wait_o,
    output logic             beat_o
);
    localparam int BPG = (GRP_WORDS * WORD_W) / BUS_W;

    logic              accept;
    logic              reject;
    logic              last_beat;
    logic [ADDR_W-1:0] ptr;
    logic              cur_rw;
    logic              store_we;
    logic [BUS_W-1:0]  rdata;

    blk_cmd_check #(
        .BUS_W (BUS_W),
        .ADDR_W(ADDR_W),
        .BPG   (BPG),
        .LEN_W (LEN_W)
    ) u_check (
        .addr_i     (ad_i),
        .len_i      (cmd_len_i),
        .cmd_valid_i(cmd_valid_i),
        .accept_o   (accept),
        .reject_o   (reject)
    );

    blk_bus_seq #(
        .ADDR_W   (ADDR_W),
        .GRP_W    (LEN_W),
        .BPG      (BPG),
        .FIRST_LAT(FIRST_LAT),
        .GROUP_LAT(GROUP_LAT),
        .GAP_CYC  (GAP_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .cmd_valid_i(cmd_valid_i),
        .rw_i       (rw_i),
        .addr_i     (ad_i[ADDR_W-1:0]),
        .last_grp_i (cmd_len_i),
        .accept_i   (accept),
        .reject_i   (reject),
        .gnt_o      (gnt_o),
        .wait_o     (wait_o),
        .beat_o     (beat_o),
        .last_beat_o(last_beat),
        .ptr_o      (ptr),
        .rw_o       (cur_rw)
    );

    // Store one word on each write beat.
    assign store_we = beat_o && cur_rw;

    blk_word_store #(
        .BUS_W (BUS_W),
        .ADDR_W(ADDR_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (store_we),
        .addr_i (ptr),
        .wdata_i(ad_i),
        .rdata_o(rdata)
    );

    // Drive read data only during read beats.
    assign ad_o = (beat_o && !cur_rw) ? rdata : '0;

    // R7
    rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(beat_o && !cur_rw) |-> (ad_o == '0));
    // R8
    write_in_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_we |-> gnt_o);
endmodule

// File: tb/blk_bus_slave_bench.sv
// Single-master bench: sweeps every length over many addresses, writes then
// reads back, and checks every granted cycle against the arithmetic schedule.
module blk_bus_slave_bench;
    localparam int FL    = 40;
    localparam int GL    = 4;
    localparam int BPG   = 2;
    localparam int PER   = (GL > BPG) ? GL : BPG;
    localparam int GAP   = 2;
    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        rw = 1'b0;
    logic [1:0]  len = 2'd0;
    logic [63:0] ad_in = '0;
    logic        gnt;
    logic [63:0] ad_out;
    logic        wt;
    logic        beat;

    int n_chk = 0;
    int n_fail = 0;
    int seq_no = 1;
    bit done = 1'b0;
    logic [63:0] model [DEPTH];

    always #10 clk = ~clk;

    blk_bus_slave #(
        .FIRST_LAT(FL),
        .GROUP_LAT(GL),
        .GAP_CYC  (GAP)
    ) u_blk_bus_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req),
        .gnt_o      (gnt),
        .cmd_valid_i(cmd_valid),
        .rw_i       (rw),
        .cmd_len_i  (len),
        .ad_i       (ad_in),
        .ad_o       (ad_out),
        .wait_o     (wt),
        .beat_o     (beat)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit is_beat(input int i, input int l);
        int r;
        if (i < FL + 1) return 1'b0;
        r = i - FL - 1;
        return ((r / PER) <= l) && ((r % PER) < BPG);
    endfunction

    // One block transfer; leaves the bus granted after a completed block.
    task automatic burst(input bit w, input int l, input logic [63:0] a);
        bit fits;
        int last;
        int k;
        int seen;
        if (!gnt) begin
            req = 1'b1;
            @(negedge clk);
            chk(gnt == 1'b1, "R2 grant one cycle after request", 64'(gnt), 64'd1);
        end
        cmd_valid = 1'b1; rw = w; len = 2'(l); ad_in = a; req = 1'b0;
        fits = (a < 64'(DEPTH)) && (int'(a) + (l + 1) * BPG <= DEPTH);
        @(negedge clk);
        cmd_valid = 1'b0; ad_in = '0;
        if (!fits) begin
            for (int z = 0; z < 2; z++) begin
                chk({gnt, wt, beat} == 3'b000, "R10 refused block: no grant/wait/beat",
                    64'({gnt, wt, beat}), 64'd0);
                @(negedge clk);
            end
            return;
        end
        last = FL + 1 + l * PER + BPG - 1;
        k = 0;
        seen = 0;
        for (int i = 1; i <= last; i++) begin
            bit eb;
            eb = is_beat(i, l);
            chk(gnt == 1'b1, "R2 grant held through block", 64'(gnt), 64'd1);
            if (i == 1)
                chk(wt == 1'b1, "R3 wait right after command", 64'(wt), 64'd1);
            if (i <= FL + 1)
                chk({beat, wt} == {eb, !eb}, "R5 first-access schedule",
                    64'({beat, wt}), 64'({eb, !eb}));
            else
                chk({beat, wt} == {eb, !eb}, "R6 group schedule",
                    64'({beat, wt}), 64'({eb, !eb}));
            if (beat) seen++;
            if (eb) begin
                if (w) begin
                    ad_in = {32'(seq_no), 16'(a), 16'(k)};
                    model[int'(a) + k] = ad_in;
                    seq_no++;
                end else begin
                    chk(ad_out == model[int'(a) + k], "R7 read order / R8 stored write",
                        ad_out, model[int'(a) + k]);
                end
                k++;
            end else if (!w) begin
                chk(ad_out == '0, "R7 bus quiet outside beats", ad_out, 64'd0);
            end
            if (i == last) req = 1'b1;
            @(negedge clk);
            ad_in = '0;
        end
        chk(seen == (l + 1) * BPG, "R4 beat count for length code", 64'(seen),
            64'((l + 1) * BPG));
        chk({gnt, beat} == 2'b00, "R9 gap cycle 1", 64'({gnt, beat}), 64'd0);
        @(negedge clk);
        chk({gnt, beat} == 2'b00, "R9 gap cycle 2", 64'({gnt, beat}), 64'd0);
        @(negedge clk);
        chk(gnt == 1'b1, "R9 regrant after gap", 64'(gnt), 64'd1);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        chk({gnt, wt, beat} == 3'b000 && ad_out == '0, "R1 outputs in reset",
            64'({gnt, wt, beat}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({gnt, wt, beat} == 3'b000 && ad_out == '0, "R1 outputs after reset",
            64'({gnt, wt, beat}), 64'd0);
        // R1: cleared array reads zero
        burst(1'b0, 3, 64'd8);
        // Sweep every length over stepped start addresses: write, then read back.
        for (int l = 0; l < 4; l++) begin
            for (int a = 0; a + (l + 1) * BPG <= DEPTH; a += 5) begin
                burst(1'b1, l, 64'(a));
                burst(1'b0, l, 64'(a));
            end
        end
        // Block ending exactly at the array top is accepted.
        burst(1'b1, 3, 64'd24);
        burst(1'b0, 3, 64'd24);
        // R10: overrunning and high-address blocks are refused, array untouched.
        burst(1'b1, 1, 64'd30);
        burst(1'b1, 3, 64'd25);
        burst(1'b1, 0, 64'h100);
        burst(1'b0, 0, 64'd31);
        burst(1'b0, 1, 64'd28);
        burst(1'b0, 3, 64'd24);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule